// File: doc/BRIEF.md
# Display Link Short-Header Builder with ECC

This block assembles the 32-bit header that starts every packet on a serial display link. It takes a 6-bit data type, a 2-bit virtual channel and a payload that is one of three things: two data bytes, a single data byte, or a 16-bit word count for a long packet. It places these fields in their fixed bit positions and adds a 6-bit Hamming-style check code in the top byte. The two highest header bits are always zero.

Requests arrive on a valid/ready handshake. The packed header leaves through a registered valid/ready output one cycle after acceptance. A stalled output holds its word and stops further input until the word is taken. If the consumer is always ready, the block accepts one header per cycle.

Top module: `dlh_hdr_gen`

## Requirements
- R1: For payload kind 0 (two bytes) and kind 3 (handled the same as kind 0), the header carries the data type in bits 5:0, the virtual channel in bits 7:6, the first byte in bits 15:8 and the second byte in bits 23:16.
- R2: For payload kind 1 (word count), the low byte of the count is in bits 15:8 and the high byte is in bits 23:16. Both byte inputs are ignored.
- R3: For payload kind 2 (single byte), the first byte is in bits 15:8 and bits 23:16 are zero whatever the second byte input holds.
- R4: Header bits 29:24 are a check code. Each bit is the XOR of a fixed set of header bits 23:0. Code bit 0 covers {0,1,2,4,5,7,10,11,13,16,20,21,22,23}. Code bit 1 covers {0,1,3,4,6,8,10,12,14,17,20,21,22,23}. Code bit 2 covers {0,2,3,5,6,9,11,12,15,18,20,21,22}. Code bit 3 covers {1,2,3,7,8,9,13,14,15,19,20,21,23}. Code bit 4 covers {4..9,16..20,22,23}. Code bit 5 covers {10..19,21,22,23}.
- R5: Header bits 31:30 are always zero.
- R6: A header accepted on a clock edge (in_valid and in_ready both high) is presented with out_valid high after that same edge.
- R7: While out_valid is high and out_ready is low, in_ready is low, and out_hdr and out_valid hold their values into the next cycle.
- R8: During and right after synchronous reset, out_valid is low and in_ready is high.
- R9: Whenever out_ready is high, in_ready is high, so one header per cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_kind | input | 2 | Payload kind: 0 two bytes, 1 word count, 2 single byte, 3 as 0 |
| in_dtype | input | 6 | Packet data type |
| in_vchan | input | 2 | Virtual channel |
| in_byte0 | input | 8 | First payload byte |
| in_byte1 | input | 8 | Second payload byte |
| in_wcount | input | 16 | Word count for long packets |
| out_valid | output | 1 | Header present |
| out_ready | input | 1 | Consumer takes header |
| out_hdr | output | 32 | Packed header with check code |

## Verification
The bench builds the block with the default field widths from the package. These widths are the only ones the fixed 24-bit code is defined for, so every code bit and every field boundary can be reached. Random headers over all four payload kinds run against a randomly stalling consumer. This exercises back-pressure with an accept and a drain in the same cycle, as well as long stalls. Directed sync-start/end headers with known check bytes anchor the code table. All-ones and all-zeros bodies test the parity extremes.

// File: rtl/dlh_pkg.sv
// dlh_pkg: field widths, payload kinds and the check-code coverage table
// shared by the header builder. Assumes a 24-bit header body.
package dlh_pkg;
    localparam int DT_W     = 6;
    localparam int VC_W     = 2;
    localparam int BYTE_W   = 8;
    localparam int WC_W     = 2 * BYTE_W;
    localparam int BODY_W   = DT_W + VC_W + 2 * BYTE_W;
    localparam int ECC_W    = 6;
    localparam int HDR_W    = 32;
    localparam int KIND_W   = 2;

    typedef enum logic [KIND_W-1:0] {
        KIND_TWO_BYTE = 2'd0,
        KIND_WCOUNT   = 2'd1,
        KIND_ONE_BYTE = 2'd2,
        KIND_ALT_TWO  = 2'd3
    } pay_kind_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
        logic [VC_W-1:0]   vc;
        logic [DT_W-1:0]   dt;
    } hdr_body_t;

    // Header-body bits that feed each check-code bit.
    function automatic logic [BODY_W-1:0] ecc_cover(input int k);
        case (k)
            0:       ecc_cover = 24'hF12CB7;
            1:       ecc_cover = 24'hF2555B;
            2:       ecc_cover = 24'h749A6D;
            3:       ecc_cover = 24'hB8E38E;
            4:       ecc_cover = 24'hDF03F0;
            5:       ecc_cover = 24'hEFFC00;
            default: ecc_cover = '0;
        endcase
    endfunction
endpackage

// File: rtl/dlh_field_pack.sv
// dlh_field_pack: places type, channel and payload into the 24-bit body.
// Assumes in_kind is one of the pay_kind_e codes; code 3 acts as code 0.
module dlh_field_pack
    import dlh_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    input  logic [DT_W-1:0]   dtype,
    input  logic [VC_W-1:0]   vchan,
    input  logic [BYTE_W-1:0] byte0,
    input  logic [BYTE_W-1:0] byte1,
    input  logic [WC_W-1:0]   wcount,
    output hdr_body_t         body
);
    // Choose payload bytes by kind and pack the fixed fields.
    always_comb begin
        body.dt = dtype;
        body.vc = vchan;
        case (pay_kind_e'(kind))
            KIND_WCOUNT: begin
                body.lo = wcount[BYTE_W-1:0];
                body.hi = wcount[WC_W-1:BYTE_W];
            end
            KIND_ONE_BYTE: begin
                body.lo = byte0;
                body.hi = '0;
            end
            default: begin
                body.lo = byte0;
                body.hi = byte1;
            end
        endcase
    end
endmodule

// File: rtl/dlh_ecc_gen.sv
// dlh_ecc_gen: one XOR tree per check-code bit over the header body.
// Assumes the coverage table in dlh_pkg matches BODY_W.
module dlh_ecc_gen
    import dlh_pkg::*;
#(
    parameter int N_BODY = BODY_W,
    parameter int N_ECC  = ECC_W
) (
    input  logic [N_BODY-1:0] body,
    output logic [N_ECC-1:0]  ecc
);
    for (genvar k = 0; k < N_ECC; k++) begin : g_par
        // Parity of the body bits this code bit covers.
        assign ecc[k] = ^(body & ecc_cover(k));
    end
endmodule

// File: rtl/dlh_out_stage.sv
// dlh_out_stage: single registered slot with valid/ready on both sides.
// Assumes the producer keeps its data steady while in_valid waits.
module dlh_out_stage #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    assign in_ready = !out_valid || out_ready;

    // Slot occupancy: refilled or drained whenever the slot can move.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_valid <= 1'b0;
        else if (in_ready) out_valid <= in_valid;
    end

    // Slot data: loaded on every accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)                    out_data <= '0;
        else if (in_valid && in_ready) out_data <= in_data;
    end

    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    a_r7_no_accept_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
    a_r6_present_next: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/dlh_hdr_gen.sv
// dlh_hdr_gen: builds a display-link packet header with its check code and
// registers it behind a valid/ready handshake (one cycle of latency).
// Assumes the default package widths (24-bit body, 6-bit code, 32-bit word).
module dlh_hdr_gen
    import dlh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [KIND_W-1:0] in_kind,
    input  logic [DT_W-1:0]   in_dtype,
    input  logic [VC_W-1:0]   in_vchan,
    input  logic [BYTE_W-1:0] in_byte0,
    input  logic [BYTE_W-1:0] in_byte1,
    input  logic [WC_W-1:0]   in_wcount,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [HDR_W-1:0]  out_hdr
);
    localparam int PAD_W = HDR_W - ECC_W - BODY_W;

    hdr_body_t          body;
    logic [ECC_W-1:0]   ecc;
    logic [HDR_W-1:0]   hdr_word;

    dlh_field_pack u_pack (
        .kind   (in_kind),
        .dtype  (in_dtype),
        .vchan  (in_vchan),
        .byte0  (in_byte0),
        .byte1  (in_byte1),
        .wcount (in_wcount),
        .body   (body)
    );

    dlh_ecc_gen #(.N_BODY(BODY_W), .N_ECC(ECC_W)) u_ecc (
        .body (body),
        .ecc  (ecc)
    );

    assign hdr_word = {{PAD_W{1'b0}}, ecc, body};

    dlh_out_stage #(.W(HDR_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (hdr_word),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_hdr)
    );

    a_r1_type_chan: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_hdr[7:0] == {$past(in_vchan), $past(in_dtype)}));
    a_r2_wcount_place: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_kind == KIND_WCOUNT) |=> (out_hdr[23:8] == $past(in_wcount)));
    a_r3_one_byte_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_kind == KIND_ONE_BYTE) |=> (out_hdr[23:16] == '0));
    a_r4_zero_body_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_kind == KIND_TWO_BYTE && in_dtype == '0 &&
         in_vchan == '0 && in_byte0 == '0 && in_byte1 == '0) |=> (out_hdr == '0));
    a_r9_ready_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> in_ready);
endmodule

// File: tb/dlh_hdr_gen_tb_top.sv
module dlh_hdr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_kind = '0;
    logic [5:0]  in_dtype = '0;
    logic [1:0]  in_vchan = '0;
    logic [7:0]  in_byte0 = '0;
    logic [7:0]  in_byte1 = '0;
    logic [15:0] in_wcount = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_hdr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    logic [31:0] exp_q[$];
    bit   follow_pending = 0;
    bit   was_stalled = 0;
    logic [31:0] held_hdr = '0;

    always #2 clk = ~clk;

    dlh_hdr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_kind(in_kind), .in_dtype(in_dtype), .in_vchan(in_vchan),
        .in_byte0(in_byte0), .in_byte1(in_byte1), .in_wcount(in_wcount),
        .out_valid(out_valid), .out_ready(out_ready), .out_hdr(out_hdr)
    );

    // Membership of body bit i in check-code bit p (R4).
    function automatic bit covers(int p, int i);
        case (p)
            0: return i inside {0,1,2,4,5,7,10,11,13,16,[20:23]};
            1: return i inside {0,1,3,4,6,8,10,12,14,17,[20:23]};
            2: return i inside {0,2,3,5,6,9,11,12,15,18,20,21,22};
            3: return i inside {1,2,3,7,8,9,13,14,15,19,20,21,23};
            4: return i inside {[4:9],[16:20],22,23};
            5: return i inside {[10:19],21,22,23};
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] model(logic [1:0] k, logic [5:0] dt, logic [1:0] vc,
                                          logic [7:0] b0, logic [7:0] b1, logic [15:0] wc);
        logic [23:0] b;
        logic [5:0]  e;
        case (k)
            2'd1:    b = {wc[15:8], wc[7:0], vc, dt};
            2'd2:    b = {8'h00, b0, vc, dt};
            default: b = {b1, b0, vc, dt};
        endcase
        for (int p = 0; p < 6; p++) begin
            e[p] = 1'b0;
            for (int i = 0; i < 24; i++) if (covers(p, i)) e[p] ^= b[i];
        end
        return {2'b00, e, b};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: sample just after the falling edge, then move to the next one.
    task automatic cycle();
        logic [31:0] e;
        #1;
        if (follow_pending) check(out_valid, "R6 present after accept", {31'd0, out_valid}, 32'd1);
        if (was_stalled) check(out_valid && out_hdr == held_hdr, "R7 hold while stalled", out_hdr, held_hdr);
        if (out_valid && !out_ready) check(!in_ready, "R7 input blocked", {31'd0, in_ready}, 32'd0);
        if (out_ready) check(in_ready, "R9 ready when drained", {31'd0, in_ready}, 32'd1);
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) check(0, "R6 unexpected output", out_hdr, 32'hx);
            else begin
                e = exp_q.pop_front();
                check(out_hdr == e, "R1/R2/R3/R4/R5 header content", out_hdr, e);
            end
        end
        was_stalled = out_valid && !out_ready;
        held_hdr = out_hdr;
        follow_pending = in_valid && in_ready;
        if (in_valid && in_ready)
            exp_q.push_back(model(in_kind, in_dtype, in_vchan, in_byte0, in_byte1, in_wcount));
        @(negedge clk);
    endtask

    task automatic directed(logic [1:0] k, logic [5:0] dt, logic [1:0] vc, logic [7:0] b0,
                            logic [7:0] b1, logic [15:0] wc, logic [31:0] want, string req);
        in_kind = k; in_dtype = dt; in_vchan = vc; in_byte0 = b0; in_byte1 = b1;
        in_wcount = wc; in_valid = 1'b1; out_ready = 1'b1;
        cycle();
        check(out_valid && out_hdr == want, req, out_hdr, want);
        in_valid = 1'b0;
        cycle();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(!out_valid && in_ready, "R8 reset state", {30'd0, out_valid, in_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && in_ready, "R8 after reset", {30'd0, out_valid, in_ready}, 32'd1);

        // Known sync headers anchor the code table (R4).
        directed(2'd0, 6'h21, 2'd0, 8'h00, 8'h00, 16'h0000, 32'h12000021, "R4 sync-start code");
        directed(2'd0, 6'h01, 2'd0, 8'h00, 8'h00, 16'h0000, 32'h07000001, "R4 vsync code");
        directed(2'd0, 6'h31, 2'd0, 8'h00, 8'h00, 16'h0000, 32'h01000031, "R4 sync-end code");
        directed(2'd0, 6'h3F, 2'd3, 8'hFF, 8'hFF, 16'h0000, model(2'd0, 6'h3F, 2'd3, 8'hFF, 8'hFF, 0), "R5 all-ones body");
        directed(2'd0, 6'h00, 2'd0, 8'h00, 8'h00, 16'hFFFF, 32'h00000000, "R1 zero body");
        directed(2'd0, 6'h15, 2'd2, 8'hA5, 8'h3C, 16'h0000, model(2'd0, 6'h15, 2'd2, 8'hA5, 8'h3C, 0), "R1 field layout");
        directed(2'd3, 6'h15, 2'd1, 8'h5A, 8'hC3, 16'h0000, model(2'd0, 6'h15, 2'd1, 8'h5A, 8'hC3, 0), "R1 kind 3 as kind 0");
        directed(2'd1, 6'h39, 2'd0, 8'hEE, 8'hDD, 16'h0102, model(2'd1, 6'h39, 2'd0, 0, 0, 16'h0102), "R2 word count little-endian");
        check(out_hdr[15:8] == 8'h02 && out_hdr[23:16] == 8'h01, "R2 count bytes", out_hdr, 32'h00010200);
        directed(2'd2, 6'h15, 2'd0, 8'h36, 8'hFF, 16'hFFFF, model(2'd2, 6'h15, 2'd0, 8'h36, 0, 0), "R3 second byte ignored");
        check(out_hdr[23:16] == 8'h00, "R3 high byte zero", {24'd0, out_hdr[23:16]}, 32'd0);

        // Long stall: hold one header then release (R7).
        in_kind = 2'd0; in_dtype = 6'h29; in_vchan = 2'd1; in_byte0 = 8'h11; in_byte1 = 8'h22;
        in_valid = 1'b1; out_ready = 1'b1;
        cycle();
        out_ready = 1'b0; in_dtype = 6'h0A;
        repeat (5) cycle();
        out_ready = 1'b1;
        cycle();
        in_valid = 1'b0;
        repeat (3) cycle();

        // Random traffic against a randomly stalling consumer.
        for (int n = 0; n < 3000; n++) begin
            in_valid  = ($urandom % 4) != 0;
            out_ready = ($urandom % 3) != 0;
            if (!(in_valid && !in_ready)) begin
                in_kind   = 2'($urandom);
                in_dtype  = 6'($urandom);
                in_vchan  = 2'($urandom);
                in_byte0  = 8'($urandom);
                in_byte1  = 8'($urandom);
                in_wcount = 16'($urandom);
            end
            cycle();
        end
        in_valid = 1'b0; out_ready = 1'b1;
        repeat (3) cycle();
        check(exp_q.size() == 0, "R6 all headers delivered", exp_q.size(), 32'd0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R6 actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule